// File: doc/BRIEF.md
# PCM Long-Frame Serial Audio Transmitter

This block turns parallel audio samples into a serial bit stream framed by a long synchronization pulse. A clock generator outside the block supplies a one-cycle enable pulse, `bclk_tick`, at twice the bit rate. Each bit period is made of two ticks. The first tick opens the bit: the data and the word-select line change there, and the serial clock sits at its idle level. The second tick moves the serial clock to the opposite level, so a receiver samples on that edge.

Every frame opens with the word-select line high for a fixed run of bit periods. The most significant bit of the sample goes out in the same bit period in which word select rises. The sample has sixteen bits, sent most significant first. When the wide-slot setting is on, sixteen zero bits follow the data, which gives a 32-bit slot. Frames follow one another with no gap.

The next sample is taken through a valid/ready handshake on the tick that opens a frame. If no sample is offered then, the frame carries zeros and an underrun flag is raised for that frame.

Top module: `pcm_lf_tx`

## Requirements
- R1: While `enable` is low and after reset, `ws`, `sdata` and `underrun` are 0, `smp_ready` is 0, and `sclk` equals `cfg_cpol`.
- R2: `ws` is 1 during the first 13 bit periods of every frame and 0 during the rest of the slot.
- R3: Bit k of a frame (k = 0..15) carries sample bit 15-k, so bit 0 is the MSB, in the same bit period in which `ws` rises.
- R4: With `cfg_wide` = 1 at the start of a frame, the slot is 32 bit periods long and bits 16..31 are 0.
- R5: With `cfg_wide` = 0 at the start of a frame, the slot is 16 bit periods long, and the next frame's bit 0 follows bit 15 directly.
- R6: Each bit period spans two ticks. After the first tick `sclk` equals `cfg_cpol`. After the second tick it equals the inverse of `cfg_cpol`. `sdata` and `ws` change only on the first tick of a bit period.
- R7: `smp_ready` is 1 only in a cycle with `bclk_tick` and `enable` both high in which the tick opens bit 0 of a frame. This includes the first tick after `enable` rises. The sample is taken when `smp_valid` is 1 in that cycle.
- R8: If `smp_valid` is 0 when a frame opens, the frame sends all zeros and `underrun` is 1 for that frame. A frame that loads a valid sample clears `underrun`.
- R9: In cycles without `bclk_tick`, `sclk`, `sdata`, `ws` and `underrun` hold their values.
- R10: Dropping `enable` returns all outputs to the R1 idle state on the next clock. The next tick after `enable` returns starts a new frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the transmitter; low forces idle |
| bclk_tick | input | 1 | Half-bit-period enable pulse from the clock generator |
| cfg_wide | input | 1 | 1: 32-bit slot with zero padding, 0: 16-bit slot |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| smp_data | input | 16 | Next audio sample |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken this cycle |
| sclk | output | 1 | Serial bit clock |
| sdata | output | 1 | Serial data |
| ws | output | 1 | Word select, long frame sync |
| underrun | output | 1 | Current frame is zero-filled for lack of a sample |

## Verification
On every cycle, the embedded properties check these rules:
- word select rises only at bit 0 and is low beyond the sync length;
- state holds between ticks;
- the padding bits are zero;
- the ready signal is tied to a tick;
- a missed sample raises the underrun flag;
- disabling clears the frame state.

Other behaviour can only be seen through the bench's sweeps. These sweeps cover both clock polarities and both slot lengths, with irregular gaps between ticks, and restart after an abort. They show the exact bit order of each sample, the 13-bit sync length, back-to-back frame joins, and the serial clock level in each half-bit.

// File: rtl/pcm_lf_pkg.sv
package pcm_lf_pkg;

    localparam int DEF_DATA_W    = 16;
    localparam int DEF_SYNC_BITS = 13;

    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } half_e;

    typedef struct packed {
        logic frame_start;
        logic bit_adv;
    } seq_ev_t;

    function automatic int slot_bits(input logic wide, input int dw);
        return wide ? 2 * dw : dw;
    endfunction

    function automatic logic sclk_level(input logic cpol, input logic active, input half_e ph);
        return cpol ^ (active & (ph == PH_TRAIL));
    endfunction

endpackage

// File: rtl/pcm_lf_framer.sv
module pcm_lf_framer
    import pcm_lf_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int SYNC_BITS = DEF_SYNC_BITS,
    localparam int CNT_W    = $clog2(2 * DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             bclk_tick,
    input  logic             cfg_wide,
    output seq_ev_t          ev,
    output logic             running,
    output half_e            phase,
    output logic [CNT_W-1:0] bitcnt,
    output logic             wide_act,
    output logic             ws
);

    logic             running_q;
    half_e            phase_q;
    logic [CNT_W-1:0] bitcnt_q;
    logic             wide_q;
    logic             ws_q;
    logic             tick;
    logic             at_last;
    logic             end_trail;
    logic [CNT_W-1:0] bit_nxt;

    always_comb begin
        tick      = bclk_tick & enable;
        at_last   = (int'(bitcnt_q) == slot_bits(wide_q, DATA_W) - 1);
        end_trail = tick & running_q & (phase_q == PH_TRAIL);
        bit_nxt   = bitcnt_q + 1'b1;
        ev.frame_start = (tick & ~running_q) | (end_trail & at_last);
        ev.bit_adv     = end_trail & ~at_last;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            running_q <= 1'b0;
            phase_q   <= PH_LEAD;
            bitcnt_q  <= '0;
            wide_q    <= 1'b0;
            ws_q      <= 1'b0;
        end else if (ev.frame_start) begin
            running_q <= 1'b1;
            phase_q   <= PH_LEAD;
            bitcnt_q  <= '0;
            wide_q    <= cfg_wide;
            ws_q      <= 1'b1;
        end else if (ev.bit_adv) begin
            phase_q   <= PH_LEAD;
            bitcnt_q  <= bit_nxt;
            ws_q      <= (int'(bit_nxt) < SYNC_BITS);
        end else if (tick) begin
            phase_q   <= PH_TRAIL;
        end
    end

    assign running  = running_q;
    assign phase    = phase_q;
    assign bitcnt   = bitcnt_q;
    assign wide_act = wide_q;
    assign ws       = ws_q;

    a_r2_ws_rises_at_bit0: assert property (@(posedge clk) disable iff (rst)
        $rose(ws_q) |-> (bitcnt_q == '0));
    a_r2_ws_low_after_sync: assert property (@(posedge clk) disable iff (rst)
        (running_q && int'(bitcnt_q) >= SYNC_BITS) |-> !ws_q);
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (enable && !bclk_tick) |=> ($stable(bitcnt_q) && $stable(ws_q) && $stable(phase_q)));
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!running_q && !ws_q && phase_q == PH_LEAD));

endmodule

// File: rtl/pcm_lf_shifter.sv
module pcm_lf_shifter
    import pcm_lf_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  seq_ev_t           ev,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic              sdata,
    output logic              underrun
);

    logic [DATA_W-1:0] sh_q;
    logic              sd_q;
    logic              und_q;

    assign smp_ready = ev.frame_start;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            sh_q  <= '0;
            sd_q  <= 1'b0;
            und_q <= 1'b0;
        end else if (ev.frame_start) begin
            if (smp_valid) begin
                sd_q  <= smp_data[DATA_W-1];
                sh_q  <= {smp_data[DATA_W-2:0], 1'b0};
                und_q <= 1'b0;
            end else begin
                sd_q  <= 1'b0;
                sh_q  <= '0;
                und_q <= 1'b1;
            end
        end else if (ev.bit_adv) begin
            sd_q <= sh_q[DATA_W-1];
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign sdata    = sd_q;
    assign underrun = und_q;

    a_r8_miss_flags_underrun: assert property (@(posedge clk) disable iff (rst)
        (enable && ev.frame_start && !smp_valid) |=> (und_q && !sd_q));
    a_r8_load_clears_underrun: assert property (@(posedge clk) disable iff (rst)
        (enable && ev.frame_start && smp_valid) |=> !und_q);
    a_r9_data_hold_no_event: assert property (@(posedge clk) disable iff (rst)
        (enable && !ev.frame_start && !ev.bit_adv) |=> ($stable(sd_q) && $stable(und_q)));

endmodule

// File: rtl/pcm_lf_tx.sv
module pcm_lf_tx
    import pcm_lf_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int SYNC_BITS = DEF_SYNC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bclk_tick,
    input  logic              cfg_wide,
    input  logic              cfg_cpol,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic              sclk,
    output logic              sdata,
    output logic              ws,
    output logic              underrun
);

    localparam int CNT_W = $clog2(2 * DATA_W);

    seq_ev_t          ev;
    logic             running;
    half_e            phase;
    logic [CNT_W-1:0] bitcnt;
    logic             wide_act;

    pcm_lf_framer #(
        .DATA_W   (DATA_W),
        .SYNC_BITS(SYNC_BITS)
    ) i_framer (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .bclk_tick(bclk_tick),
        .cfg_wide (cfg_wide),
        .ev       (ev),
        .running  (running),
        .phase    (phase),
        .bitcnt   (bitcnt),
        .wide_act (wide_act),
        .ws       (ws)
    );

    pcm_lf_shifter #(
        .DATA_W(DATA_W)
    ) i_shifter (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .ev       (ev),
        .smp_data (smp_data),
        .smp_valid(smp_valid),
        .smp_ready(smp_ready),
        .sdata    (sdata),
        .underrun (underrun)
    );

    assign sclk = sclk_level(cfg_cpol, running, phase);

    a_r4_zero_padding: assert property (@(posedge clk) disable iff (rst)
        (running && wide_act && int'(bitcnt) >= DATA_W) |-> !sdata);
    a_r7_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> (bclk_tick && enable));
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!ws && !sdata && !underrun && sclk == cfg_cpol));

endmodule

// File: tb/test_pcm_lf_tx.sv
`timescale 1ns/1ps
module test_pcm_lf_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        bclk_tick = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, sclk, sdata, ws, underrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic e_sclk, e_sd, e_ws, e_und;

    always #4 clk = ~clk;

    pcm_lf_tx i_pcm_lf_tx (
        .clk(clk), .rst(rst), .enable(enable), .bclk_tick(bclk_tick),
        .cfg_wide(cfg_wide), .cfg_cpol(cfg_cpol), .smp_data(smp_data),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .sclk(sclk),
        .sdata(sdata), .ws(ws), .underrun(underrun)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string r_sd, input string r_ws, input string r_ck, input string r_un);
        chk(r_sd, "sdata", sdata, e_sd);
        chk(r_ws, "ws", ws, e_ws);
        chk(r_ck, "sclk", sclk, e_sclk);
        chk(r_un, "underrun", underrun, e_und);
    endtask

    task automatic idle_check(input string req);
        e_sclk = cfg_cpol; e_sd = 1'b0; e_ws = 1'b0; e_und = 1'b0;
        check_outs(req, req, req, req);
        chk(req, "smp_ready", smp_ready, 1'b0);
    endtask

    // one tick with ready check; called at a negedge
    task automatic do_tick(input logic exp_ready);
        bclk_tick = 1'b1;
        #1;
        chk("R7", "smp_ready", smp_ready, exp_ready);
        @(posedge clk);
        @(negedge clk);
        bclk_tick = 1'b0;
    endtask

    // frames of a configuration; limit_half > 0 stops early
    task automatic run_cfg(input logic cpol, input logic wide, input int nframes, input int limit_half);
        int len;
        int halves;
        cfg_cpol = cpol;
        cfg_wide = wide;
        #1;
        idle_check("R1");
        enable = 1'b1;
        len = wide ? 32 : 16;
        halves = 0;
        for (int f = 0; f < nframes; f++) begin
            logic [15:0] s;
            logic        v;
            s = 16'(f * 16'h3A5B + 16'h8001 + (cpol ? 16'h0F0F : 16'h0) + (wide ? 16'h1234 : 16'h0));
            v = (f % 3) != 2;
            smp_data  = s;
            smp_valid = v;
            for (int k = 0; k < len; k++) begin
                for (int h = 0; h < 2; h++) begin
                    if (limit_half > 0 && halves >= limit_half) return;
                    do_tick(k == 0 && h == 0);
                    if (k == 0 && h == 0) begin
                        smp_valid = 1'b0;
                        smp_data  = ~s;
                    end
                    halves++;
                    e_sclk = cpol ^ h[0];
                    e_sd   = (k < 16 && v) ? s[15-k] : 1'b0;
                    e_ws   = (k < 13);
                    e_und  = ~v;
                    check_outs((k >= 16) ? "R4" : ((k == 0 && f > 0 && !wide) ? "R5" : "R3"),
                               "R2", "R6", "R8");
                    for (int g = 0; g < (k + h + f) % 3; g++) begin
                        @(negedge clk);
                        check_outs("R9", "R9", "R9", "R9");
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1");
        for (int c = 0; c < 4; c++) begin
            run_cfg(c[0], c[1], 4, 0);
            enable = 1'b0;
            @(negedge clk);
            idle_check("R10");
        end
        // abort mid-frame, then restart
        run_cfg(1'b0, 1'b1, 1, 21);
        enable = 1'b0;
        @(negedge clk);
        idle_check("R10");
        bclk_tick = 1'b1;
        @(negedge clk);
        bclk_tick = 1'b0;
        idle_check("R10");
        run_cfg(1'b1, 1'b0, 2, 0);
        enable = 1'b0;
        @(negedge clk);
        idle_check("R10");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule